// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

This block is a small accumulator machine in which every register transfer travels over one shared internal bus. A control sequencer steps each instruction through a fetch phase, an optional indirect-address phase, an execute phase and, when a request is pending, an interrupt phase. In each clock it raises at most one bus out-enable and any number of in-enables. Two latches sit around the adder: Y holds the second operand and Z holds the sum. A transfer that would need two bus drivers is therefore spread over successive cycles.

Memory is reached through an address register and a data register over a request/ready port. `mem_rd` or `mem_wr` acts as the valid signal for a request, and `mem_ready` acts as the ready signal. A transfer completes in the clock where both are high. Until then the block holds the request, `mem_addr` and `mem_wdata` unchanged, so memory may apply back-pressure for any number of cycles. Read data is taken from `mem_rdata` in the completing cycle only.

Instruction word (16 bits): opcode in [15:12], indirect flag in bit 11, address in [10:0]. The opcodes are 0 load, 1 add, 2 store, 3 jump and F halt.

Top module: `acc_bus_cpu`

## Requirements
- R1: `rst` is synchronous and active high. It clears the program counter and the accumulator, sets the interrupt enable, and restarts at a fetch. The first request after release is a read of address 0, and `irq_ack`, `halted`, `mem_rd` and `mem_wr` are low while reset is applied.
- R2: Fetch reads the word at the program counter, and the program counter then advances by one. Instructions run in address order unless a jump or an interrupt intervenes.
- R3: Opcode 0 copies the operand word into the accumulator. Opcode 1 adds the operand word to the accumulator, modulo 2^16.
- R4: Opcode 2 writes the accumulator to the effective address.
- R5: With bit 11 set, the effective address is the low 11 bits of the word read from the instruction's address field. With bit 11 clear, the address field itself is the effective address.
- R6: Opcode 3 loads the program counter with the effective address, direct or indirect.
- R7: Opcode F stops the block. `halted` goes high and stays high, and no memory request is issued, until reset.
- R8: Any opcode other than 0, 1, 2, 3 and F leaves memory and the accumulator unchanged, and execution continues at the next word.
- R9: A request holds its kind, `mem_addr` and (for writes) `mem_wdata` stable until `mem_ready` is seen. `mem_rd` and `mem_wr` are never high together.
- R10: `irq` is sampled only as an instruction's execute phase ends, and only while the interrupt enable is set. When taken, the block writes the program counter to address 0, loads the program counter with 1, clears the enable so the request is taken only once, and raises `irq_ack` for exactly one cycle, right after that write.
- R11: At most one source drives the internal bus in any cycle. An add moves the operand to Y, latches the sum in Z, and then moves Z to the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request, level |
| irq_ack | output | 1 | One-cycle pulse when an interrupt is taken |
| halted | output | 1 | High after a halt instruction until reset |
| mem_addr | output | 11 | Memory address (address register) |
| mem_wdata | output | 16 | Write data (data register) |
| mem_rdata | input | 16 | Read data, valid when mem_ready is high |
| mem_rd | output | 1 | Read request (valid) |
| mem_wr | output | 1 | Write request (valid) |
| mem_ready | input | 1 | Memory accepts the current request |

## Verification
The bench runs a program with zero-latency memory and then one with a three-cycle ready delay and a level interrupt held high from reset. Indirect load, store and jump catch a design that uses the pointer word's address instead of the word it points to. Such a design would write to the wrong location or jump to the wrong place. An add that overflows 16 bits shows up as a wrong stored value if the sum is not truncated. An unlisted opcode and a jump over a store word would produce an unexpected write if they were executed. The held interrupt catches a design that does not clear its enable (it would write to address 0 repeatedly and pulse `irq_ack` more than once) and a design that saves the wrong breakpoint. A store right after reset exposes an accumulator that reset does not clear.

// File: rtl/acc_bus_pkg.sv
package acc_bus_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h0;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_JMP   = 4'h3;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

  // bus source slots, one out-enable each
  localparam int NSRC    = 6;
  localparam int SRC_PC  = 0;
  localparam int SRC_IR  = 1;
  localparam int SRC_MDR = 2;
  localparam int SRC_ACC = 3;
  localparam int SRC_Z   = 4;
  localparam int SRC_K   = 5;

  typedef enum logic [4:0] {
    PH_F0, PH_F1, PH_F2, PH_F3,
    PH_I0, PH_I1,
    PH_E0, PH_E1, PH_E2, PH_E3, PH_E4,
    PH_S0, PH_S1,
    PH_T0, PH_T1, PH_T2, PH_T3,
    PH_HALT
  } phase_t;

  typedef struct packed {
    logic [NSRC-1:0] oe;
    logic mar_in;
    logic mdr_in;
    logic ir_in;
    logic pc_in;
    logic pc_inc;
    logic acc_in;
    logic y_in;
    logic z_in;
    logic k_one;
    logic mem_rd;
    logic mem_wr;
    logic ack;
    logic ie_clr;
  } ctl_t;
endpackage

// File: rtl/acc_bus_mux.sv
module acc_bus_mux #(
  parameter int DATA_W = 16,
  parameter int N      = 6
) (
  input  logic [N-1:0]             oe,
  input  logic [N-1:0][DATA_W-1:0] src,
  output logic [DATA_W-1:0]        bus
);
  logic [N-1:0][DATA_W-1:0] gated;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_term
      assign gated[gi] = oe[gi] ? src[gi] : '0;
    end
  endgenerate

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/acc_bus_seq.sv
module acc_bus_seq
  import acc_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic             ind,
  input  logic             irq,
  input  logic             mem_ready,
  output ctl_t             ctl,
  output logic             halted
);
  phase_t ph, ph_nx;
  logic   ie;
  phase_t end_ph;
  logic   known_op;

  assign end_ph   = (irq && ie) ? PH_T0 : PH_F0;
  assign known_op = (opc == OP_LOAD) || (opc == OP_ADD) ||
                    (opc == OP_STORE) || (opc == OP_JMP);

  always_comb begin
    ctl   = '0;
    ph_nx = ph;
    unique case (ph)
      PH_F0: begin ctl.oe[SRC_PC] = 1'b1; ctl.mar_in = 1'b1; ph_nx = PH_F1; end
      PH_F1: begin ctl.mem_rd = 1'b1; if (mem_ready) ph_nx = PH_F2; end
      PH_F2: begin ctl.oe[SRC_MDR] = 1'b1; ctl.ir_in = 1'b1; ph_nx = PH_F3; end
      PH_F3: begin
        ctl.pc_inc = 1'b1;
        if (opc == OP_HALT)  ph_nx = PH_HALT;
        else if (!known_op)  ph_nx = end_ph;
        else if (ind)        ph_nx = PH_I0;
        else                 ph_nx = PH_E0;
      end
      PH_I0: begin ctl.oe[SRC_IR] = 1'b1; ctl.mar_in = 1'b1; ph_nx = PH_I1; end
      PH_I1: begin ctl.mem_rd = 1'b1; if (mem_ready) ph_nx = PH_E0; end
      PH_E0: begin
        if (ind) ctl.oe[SRC_MDR] = 1'b1;
        else     ctl.oe[SRC_IR]  = 1'b1;
        if (opc == OP_JMP) begin
          ctl.pc_in = 1'b1;
          ph_nx     = end_ph;
        end else begin
          ctl.mar_in = 1'b1;
          ph_nx      = (opc == OP_STORE) ? PH_S0 : PH_E1;
        end
      end
      PH_E1: begin ctl.mem_rd = 1'b1; if (mem_ready) ph_nx = PH_E2; end
      PH_E2: begin
        ctl.oe[SRC_MDR] = 1'b1;
        if (opc == OP_ADD) begin
          ctl.y_in = 1'b1;
          ph_nx    = PH_E3;
        end else begin
          ctl.acc_in = 1'b1;
          ph_nx      = end_ph;
        end
      end
      PH_E3: begin ctl.z_in = 1'b1; ph_nx = PH_E4; end
      PH_E4: begin ctl.oe[SRC_Z] = 1'b1; ctl.acc_in = 1'b1; ph_nx = end_ph; end
      PH_S0: begin ctl.oe[SRC_ACC] = 1'b1; ctl.mdr_in = 1'b1; ph_nx = PH_S1; end
      PH_S1: begin ctl.mem_wr = 1'b1; if (mem_ready) ph_nx = end_ph; end
      PH_T0: begin ctl.oe[SRC_K] = 1'b1; ctl.mar_in = 1'b1; ph_nx = PH_T1; end
      PH_T1: begin ctl.oe[SRC_PC] = 1'b1; ctl.mdr_in = 1'b1; ph_nx = PH_T2; end
      PH_T2: begin ctl.mem_wr = 1'b1; if (mem_ready) ph_nx = PH_T3; end
      PH_T3: begin
        ctl.oe[SRC_K] = 1'b1;
        ctl.k_one     = 1'b1;
        ctl.pc_in     = 1'b1;
        ctl.ack       = 1'b1;
        ctl.ie_clr    = 1'b1;
        ph_nx         = PH_F0;
      end
      PH_HALT: ph_nx = PH_HALT;
      default: ph_nx = PH_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_F0;
      ie <= 1'b1;
    end else begin
      ph <= ph_nx;
      if (ctl.ie_clr) ie <= 1'b0;
    end
  end

  assign halted = (ph == PH_HALT);
endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
  import acc_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [OPC_W-1:0]  opc,
  output logic              ind
);
  localparam int PAD_W   = DATA_W - ADDR_W;
  localparam int IND_BIT = DATA_W - OPC_W - 1;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] ir, mdr, acc, y, z;
  logic [DATA_W-1:0] bus;
  logic [NSRC-1:0][DATA_W-1:0] src;

  always_comb begin
    src          = '0;
    src[SRC_PC]  = {{PAD_W{1'b0}}, pc};
    src[SRC_IR]  = {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
    src[SRC_MDR] = mdr;
    src[SRC_ACC] = acc;
    src[SRC_Z]   = z;
    src[SRC_K]   = {{(DATA_W-1){1'b0}}, ctl.k_one};
  end

  acc_bus_mux #(.DATA_W(DATA_W), .N(NSRC)) mux_i (
    .oe  (ctl.oe),
    .src (src),
    .bus (bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      ir  <= '0;
      mdr <= '0;
      acc <= '0;
      y   <= '0;
      z   <= '0;
    end else begin
      if (ctl.pc_in)       pc <= bus[ADDR_W-1:0];
      else if (ctl.pc_inc) pc <= pc + 1'b1;
      if (ctl.mar_in) mar <= bus[ADDR_W-1:0];
      if (ctl.ir_in)  ir  <= bus;
      if (ctl.mem_rd && mem_ready) mdr <= mem_rdata;
      else if (ctl.mdr_in)         mdr <= bus;
      if (ctl.acc_in) acc <= bus;
      if (ctl.y_in)   y   <= bus;
      if (ctl.z_in)   z   <= acc + y;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign opc       = ir[DATA_W-1 -: OPC_W];
  assign ind       = ir[IND_BIT];
endmodule

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu
  import acc_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  output logic              irq_ack,
  output logic              halted,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic              mem_ready
);
  ctl_t             ctl;
  logic [NSRC-1:0]  bus_oe;
  logic [OPC_W-1:0] opc;
  logic             ind;

  acc_bus_seq seq_i (
    .clk       (clk),
    .rst       (rst),
    .opc       (opc),
    .ind       (ind),
    .irq       (irq),
    .mem_ready (mem_ready),
    .ctl       (ctl),
    .halted    (halted)
  );

  acc_bus_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .opc       (opc),
    .ind       (ind)
  );

  assign bus_oe  = ctl.oe;
  assign mem_rd  = ctl.mem_rd;
  assign mem_wr  = ctl.mem_wr;
  assign irq_ack = ctl.ack;
endmodule

// File: rtl/acc_bus_cpu_chk.sv
module acc_bus_cpu_chk
  import acc_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   oe,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              irq_ack,
  input logic              halted
);
  // R11
  bus_single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oe));

  // R9
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  // R10
  ack_after_save_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(mem_wr && mem_ready && (mem_addr == '0)));

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_rd && !mem_wr));
endmodule

bind acc_bus_cpu acc_bus_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .oe        (bus_oe),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq_ack   (irq_ack),
  .halted    (halted)
);

// File: tb/acc_bus_cpu_tb.sv
`timescale 1ns/1ps
module acc_bus_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        irq;
  logic        irq_ack, halted;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_ready;

  always #2.5 clk = ~clk;

  acc_bus_cpu dut_i (
    .clk(clk), .rst(rst), .irq(irq), .irq_ack(irq_ack), .halted(halted),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready)
  );

  typedef struct {
    logic [10:0] a;
    logic [15:0] d;
    string       tag;
  } wr_item_t;

  wr_item_t    sb_q[$];
  logic [15:0] mem [0:2047];
  int n_chk = 0, n_fail = 0;
  int lat = 0, ack_cnt = 0, txn_cnt = 0, viol = 0;

  function automatic logic [15:0] enc(input logic [3:0] op, input logic i, input logic [10:0] a);
    return {op, i, a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [10:0] a, input logic [15:0] d, input string tag);
    wr_item_t it;
    it.a = a; it.d = d; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
  endtask

  // memory model and write monitor
  task automatic mem_loop();
    int cnt = 0;
    bit pend = 0;
    logic [10:0] pa = '0;
    bit pw = 0;
    forever begin
      @(negedge clk);
      if (irq_ack) ack_cnt++;
      if (rst) begin
        mem_ready = 1'b0; cnt = 0; pend = 0;
        continue;
      end
      if (pend && (!(mem_rd || mem_wr) || pa != mem_addr || pw != mem_wr)) viol++;
      if (mem_rd || mem_wr) begin
        if (cnt >= lat) begin
          mem_ready = 1'b1; cnt = 0; pend = 0; txn_cnt++;
          if (mem_rd) mem_rdata = mem[mem_addr];
          else begin
            mem[mem_addr] = mem_wdata;
            if (sb_q.size() == 0)
              check(1'b0, "R4/R6/R8 unexpected write addr", {21'h0, mem_addr}, 32'h0);
            else begin
              wr_item_t it = sb_q.pop_front();
              check(mem_addr == it.a, {it.tag, " write address"}, {21'h0, mem_addr}, {21'h0, it.a});
              check(mem_wdata == it.d, {it.tag, " write data"}, {16'h0, mem_wdata}, {16'h0, it.d});
            end
          end
        end else begin
          mem_ready = 1'b0; cnt++; pend = 1; pa = mem_addr; pw = mem_wr;
        end
      end else begin
        mem_ready = 1'b0; cnt = 0; pend = 0;
      end
    end
  endtask

  task automatic watchdog();
    repeat (20000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_halt();
    while (!halted) @(negedge clk);
  endtask

  task automatic quiet_after_halt(input string tag);
    int t0 = txn_cnt;
    repeat (30) @(negedge clk);
    #1;
    check(halted && txn_cnt == t0, tag, txn_cnt - t0, 0);
  endtask

  task automatic load_prog_a();
    clear_mem();
    mem[0]   = enc(4'h0, 1'b0, 11'd100);  // load 5
    mem[1]   = enc(4'h1, 1'b0, 11'd101);  // add 7
    mem[2]   = enc(4'h2, 1'b0, 11'd200);  // store 12
    mem[3]   = enc(4'h0, 1'b1, 11'd102);  // load via pointer
    mem[4]   = enc(4'h2, 1'b1, 11'd104);  // store via pointer
    mem[5]   = enc(4'h3, 1'b0, 11'd10);   // jump
    mem[6]   = enc(4'h2, 1'b0, 11'd300);  // skipped
    mem[10]  = enc(4'h1, 1'b0, 11'd105);  // add FFFF, wraps
    mem[11]  = enc(4'h2, 1'b0, 11'd202);
    mem[12]  = enc(4'h3, 1'b1, 11'd106);  // jump via pointer
    mem[13]  = enc(4'h2, 1'b0, 11'd301);  // skipped
    mem[20]  = enc(4'h7, 1'b0, 11'd300);  // unlisted opcode
    mem[21]  = enc(4'h2, 1'b0, 11'd203);
    mem[22]  = enc(4'hF, 1'b0, 11'd0);
    mem[100] = 16'h0005;
    mem[101] = 16'h0007;
    mem[102] = 16'd103;
    mem[103] = 16'h1234;
    mem[104] = 16'd201;
    mem[105] = 16'hFFFF;
    mem[106] = 16'd20;
    expect_wr(11'd200, 16'h000C, "R3 load/add");
    expect_wr(11'd201, 16'h1234, "R5 indirect load/store");
    expect_wr(11'd202, 16'h1233, "R6/R3/R11 jump then wrapped add");
    expect_wr(11'd203, 16'h1233, "R8 unlisted opcode");
  endtask

  task automatic load_prog_b();
    clear_mem();
    mem[0]   = enc(4'h2, 1'b0, 11'd201);  // store acc after reset
    mem[1]   = enc(4'h0, 1'b0, 11'd100);
    mem[2]   = enc(4'h2, 1'b0, 11'd200);
    mem[3]   = enc(4'hF, 1'b0, 11'd0);
    mem[100] = 16'h00AA;
    expect_wr(11'd201, 16'h0000, "R1 acc cleared");
    expect_wr(11'd0,   16'h0001, "R10 breakpoint saved");
    expect_wr(11'd200, 16'h00AA, "R2/R10 resumes at 1");
  endtask

  initial begin
    rst = 1'b1; irq = 1'b0; mem_ready = 1'b0; mem_rdata = '0;
    lat = 0;
    load_prog_a();
    fork
      mem_loop();
      watchdog();
    join_none
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!mem_rd && !mem_wr, "R1 no request at reset", {mem_rd, mem_wr}, 0);
    check(!irq_ack, "R1 ack low", irq_ack, 0);
    check(!halted, "R1 not halted", halted, 0);
    @(negedge clk); #1;
    check(mem_rd && mem_addr == 11'd0, "R1/R2 first fetch at 0", {mem_rd, mem_addr}, {1'b1, 11'd0});
    wait_halt();
    check(sb_q.size() == 0, "R4 all stores seen (run 1)", sb_q.size(), 0);
    quiet_after_halt("R7 halt quiet (run 1)");

    // second run: slow memory, interrupt held from reset
    @(negedge clk);
    rst = 1'b1; lat = 3; irq = 1'b1; ack_cnt = 0; viol = 0;
    load_prog_b();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_halt();
    check(sb_q.size() == 0, "R10 all stores seen (run 2)", sb_q.size(), 0);
    check(ack_cnt == 1, "R10 single ack pulse", ack_cnt, 1);
    check(viol == 0, "R9 request held during stall", viol, 0);
    quiet_after_halt("R7 halt quiet (run 2)");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule